// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every memory request of a small core, whether the access may proceed. It keeps eight protection entries, each made of a 32-bit address word and an 8-bit configuration byte. An address word stores a 34-bit physical byte address with its two low bits dropped. Each configuration byte selects how the entry matches: off, a top-of-range bound, or a naturally aligned power-of-two region. It also carries read, write and execute permissions and a lock bit.

A request gives an address, an access kind and a privilege level. The allow decision is combinational, so it arrives in the same cycle. When a valid request is refused, the block registers a fault one cycle later. The fault carries a cause code and the offending address, and a trap unit outside this block consumes them.

Software programs the entries through a simple register write and read port. The entry index picks the slot, and a select bit chooses the address word or the configuration byte.

Top module: `pmp_guard`

## Requirements
- R1: After reset every address word and configuration byte reads as zero. A write to an address word stores all 32 bits and reads back unchanged. A configuration byte stores the low 8 bits of the write data and reads back zero-extended.
- R2: The configuration byte is laid out as bit0 read, bit1 write, bit2 execute, bits 4:3 mode and bit7 lock. Mode 3 is the power-of-two mode. In it, let k be the lowest zero bit of the address word. The entry then covers 2^(k+3) bytes from a base, which is the word with bits k..0 cleared and shifted left by 2.
- R3: Mode 1 is the top-of-range mode. An entry in this mode matches byte addresses at or above the previous entry's word shifted left by 2 and strictly below its own word shifted left by 2. Entry 0 uses zero as its lower bound.
- R4: When several entries match, only the lowest-numbered one decides. An entry that refuses an access is not overridden by a permitting entry with a higher number.
- R5: The access kind is encoded as 0 for a load, 1 for a store and 2 for a fetch. Each kind is checked against the read, write and execute bit respectively.
- R6: Modes 0 and 2 disable an entry. A user-level request (priv 0) that matches no entry is allowed only when no entry is enabled.
- R7: A machine-level request (priv 1) is allowed when no entry matches, or when the matching entry is unlocked. If the matching entry is locked, its permission bits apply.
- R8: The allow output is combinational. In the clock edge after a valid request is refused, the fault valid output rises with cause 1 for a fetch, 2 for a load and 3 for a store, and the fault address is the request address. After any other cycle the fault valid output is low.
- R9: A write to an entry whose lock bit is set changes neither its address word nor its configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_is_cfg | input | 1 | 1 selects the configuration byte, 0 selects the address word |
| csr_idx | input | 3 | Entry index |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected register |
| req_valid | input | 1 | Request present |
| req_addr | input | 34 | Physical byte address |
| req_type | input | 2 | 0 load, 1 store, 2 fetch |
| req_priv | input | 1 | 0 user, 1 machine |
| allow | output | 1 | Access permitted (combinational) |
| flt_valid | output | 1 | Registered fault pulse |
| flt_cause | output | 2 | 1 fetch, 2 load, 3 store |
| flt_addr | output | 34 | Faulting byte address |

## Verification
The bench probes the first and last words inside a power-of-two region and the words just outside it on either side. A design that takes the region size from the wrong bit would leak or refuse at those edges. Top-of-range entries are tested exactly at their inclusive lower and exclusive upper bounds. An off-by-one there shifts a boundary word into the wrong entry. The bench also overlaps a refusing low entry with a permitting catch-all entry, which exposes a design that ORs the matches instead of taking the lowest one. Lock tests confirm that a locked entry binds machine level and ignores rewrites. Mode 2 is checked so that it is not mistaken for an enabled entry.

// File: rtl/pmp_guard.sv
module pmp_guard #(
  parameter int N    = 8,
  parameter int PA_W = 34,
  localparam int AW  = PA_W - 2,
  localparam int IW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr_en,
  input  logic            csr_is_cfg,
  input  logic [IW-1:0]   csr_idx,
  input  logic [AW-1:0]   csr_wdata,
  output logic [AW-1:0]   csr_rdata,
  input  logic            req_valid,
  input  logic [PA_W-1:0] req_addr,
  input  logic [1:0]      req_type,
  input  logic            req_priv,
  output logic            allow,
  output logic            flt_valid,
  output logic [1:0]      flt_cause,
  output logic [PA_W-1:0] flt_addr
);

  logic [N-1:0][AW-1:0] addr_q;
  logic [N-1:0][7:0]    cfg_q;
  logic [N-1:0]         hit;
  logic [N-1:0]         ent_on;
  logic [AW-1:0]        wa;
  logic                 found;
  logic [7:0]           sel_cfg;
  logic                 perm;

  assign wa = req_addr[PA_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cfg_q  <= '0;
    end else if (csr_wr_en && !cfg_q[csr_idx][7]) begin
      if (csr_is_cfg) cfg_q[csr_idx]  <= csr_wdata[7:0];
      else            addr_q[csr_idx] <= csr_wdata;
    end
  end

  assign csr_rdata = csr_is_cfg ? {{(AW-8){1'b0}}, cfg_q[csr_idx]} : addr_q[csr_idx];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [AW-1:0] lo;
    logic [AW-1:0] nmask;
    logic          tor_hit;
    logic          pot_hit;
    if (i == 0) begin : g_lo0
      assign lo = '0;
    end else begin : g_lo
      assign lo = addr_q[i-1];
    end
    assign nmask   = addr_q[i] ^ (addr_q[i] + 1'b1);
    assign tor_hit = (wa >= lo) && (wa < addr_q[i]);
    assign pot_hit = ((wa ^ addr_q[i]) & ~nmask) == '0;
    assign ent_on[i] = cfg_q[i][3];
    assign hit[i] = (cfg_q[i][4:3] == 2'd1) ? tor_hit :
                    (cfg_q[i][4:3] == 2'd3) ? pot_hit : 1'b0;
  end

  always_comb begin
    found   = 1'b0;
    sel_cfg = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && !found) begin
        found   = 1'b1;
        sel_cfg = cfg_q[i];
      end
    end
  end

  always_comb begin
    case (req_type)
      2'd0:    perm = sel_cfg[0];
      2'd1:    perm = sel_cfg[1];
      2'd2:    perm = sel_cfg[2];
      default: perm = 1'b0;
    endcase
  end

  assign allow = found ? ((req_priv && !sel_cfg[7]) || perm)
                       : (req_priv || (ent_on == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_cause <= '0;
      flt_addr  <= '0;
    end else begin
      flt_valid <= req_valid && !allow;
      if (req_valid && !allow) begin
        flt_addr  <= req_addr;
        flt_cause <= (req_type == 2'd2) ? 2'd1 :
                     (req_type == 2'd1) ? 2'd3 : 2'd2;
      end
    end
  end

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk #(
  parameter int N    = 8,
  parameter int PA_W = 34,
  localparam int IW  = $clog2(N)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                csr_wr_en,
  input logic                csr_is_cfg,
  input logic [IW-1:0]       csr_idx,
  input logic                req_valid,
  input logic [PA_W-1:0]     req_addr,
  input logic [1:0]          req_type,
  input logic                req_priv,
  input logic                allow,
  input logic                flt_valid,
  input logic [1:0]          flt_cause,
  input logic [PA_W-1:0]     flt_addr,
  input logic [N-1:0][7:0]   cfg_q
);

  logic any_on;
  logic any_lock;
  always_comb begin
    any_on   = 1'b0;
    any_lock = 1'b0;
    for (int i = 0; i < N; i++) begin
      any_on   = any_on   | cfg_q[i][3];
      any_lock = any_lock | cfg_q[i][7];
    end
  end

  assert_fault_follows_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !allow |=> flt_valid);

  assert_fault_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !allow |=> flt_addr == $past(req_addr));

  assert_no_spurious_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !allow) |=> !flt_valid);

  assert_store_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !allow && req_type == 2'd1 |=> flt_cause == 2'd3);

  assert_open_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_on |-> allow);

  assert_machine_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_priv && !any_lock |-> allow);

  assert_locked_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en && csr_is_cfg && cfg_q[csr_idx][7] |=> cfg_q[$past(csr_idx)] == $past(cfg_q[csr_idx]));

endmodule

bind pmp_guard pmp_guard_chk #(.N(N), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_is_cfg(csr_is_cfg),
  .csr_idx(csr_idx), .req_valid(req_valid), .req_addr(req_addr),
  .req_type(req_type), .req_priv(req_priv), .allow(allow),
  .flt_valid(flt_valid), .flt_cause(flt_cause), .flt_addr(flt_addr),
  .cfg_q(cfg_q)
);

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic        csr_is_cfg = 1'b0;
  logic [2:0]  csr_idx = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        req_valid = 1'b0;
  logic [33:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic        req_priv = 1'b0;
  logic        allow;
  logic        flt_valid;
  logic [1:0]  flt_cause;
  logic [33:0] flt_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmp_guard u0 (.*);

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; csr_wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input bit is_cfg, input int idx, input logic [31:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_is_cfg = is_cfg; csr_idx = 3'(idx); csr_wdata = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic rd(input bit is_cfg, input int idx, input logic [31:0] exp, input string what);
    @(negedge clk);
    csr_is_cfg = is_cfg; csr_idx = 3'(idx);
    #1 check(64'(csr_rdata), 64'(exp), what);
  endtask

  task automatic probe(input logic [33:0] a, input logic [1:0] t, input bit p,
                       input bit exp_ok, input string what);
    logic [1:0] ec;
    ec = (t == 2'd2) ? 2'd1 : (t == 2'd1) ? 2'd3 : 2'd2;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_type = t; req_priv = p;
    #1 check(64'(allow), 64'(exp_ok), {what, " allow"});
    @(posedge clk);
    #1 check(64'(flt_valid), 64'(!exp_ok), {what, " flt_valid"});
    if (!exp_ok) begin
      check(64'(flt_cause), 64'(ec), {what, " flt_cause"});
      check(64'(flt_addr), 64'(a), {what, " flt_addr"});
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rd(1'b0, 0, 32'h0, "R1 addr0 after reset");
    rd(1'b1, 7, 32'h0, "R1 cfg7 after reset");
    check(64'(flt_valid), 64'd0, "R8 flt_valid after reset");
    probe(34'h0_8000_0000, 2'd1, 1'b0, 1'b1, "R6 user store with no entry on");
  endtask

  task automatic t_napot();
    do_reset();
    wr(1'b0, 0, 32'h2000_0EA7);
    wr(1'b1, 0, 32'hFFFF_FF1B);
    rd(1'b0, 0, 32'h2000_0EA7, "R1 addr0 readback");
    rd(1'b1, 0, 32'h0000_001B, "R1 cfg0 readback");
    probe(34'h0_8000_3A80, 2'd0, 1'b0, 1'b1, "R2 load at base");
    probe(34'h0_8000_3ABC, 2'd0, 1'b0, 1'b1, "R2 load last word");
    probe(34'h0_8000_3AC0, 2'd0, 1'b0, 1'b0, "R2 load one past end");
    probe(34'h0_8000_3A7C, 2'd1, 1'b0, 1'b0, "R2 store below base");
    probe(34'h0_8000_3AA0, 2'd1, 1'b0, 1'b1, "R5 store with W");
    probe(34'h0_8000_3AA0, 2'd2, 1'b0, 1'b0, "R5 fetch without X");
    wr(1'b0, 1, 32'h2000_0000);
    wr(1'b1, 1, 32'h0000_0019);
    probe(34'h0_8000_0004, 2'd0, 1'b0, 1'b1, "R2 8-byte region inside");
    probe(34'h0_8000_0008, 2'd0, 1'b0, 1'b0, "R2 8-byte region outside");
  endtask

  task automatic t_tor();
    do_reset();
    wr(1'b0, 0, 32'h0000_1000);
    wr(1'b1, 0, 32'h0000_0009);
    wr(1'b0, 1, 32'h0000_2000);
    wr(1'b1, 1, 32'h0000_000B);
    probe(34'h0, 2'd0, 1'b0, 1'b1, "R3 entry0 lower bound zero");
    probe(34'h100, 2'd1, 1'b0, 1'b0, "R5 store in read-only range");
    probe(34'h3FFC, 2'd1, 1'b0, 1'b0, "R3 last word of entry0");
    probe(34'h4000, 2'd1, 1'b0, 1'b1, "R3 lower bound of entry1");
    probe(34'h7FFC, 2'd1, 1'b0, 1'b1, "R3 last word of entry1");
    probe(34'h8000, 2'd1, 1'b0, 1'b0, "R3 top bound exclusive");
    wr(1'b0, 2, 32'hFFFF_FFFF);
    wr(1'b1, 2, 32'h0000_001F);
    probe(34'h100, 2'd1, 1'b0, 1'b0, "R4 lower entry wins over catch-all");
    probe(34'h8000, 2'd1, 1'b0, 1'b1, "R4 catch-all covers rest");
  endtask

  task automatic t_machine();
    do_reset();
    wr(1'b0, 0, 32'h0000_1000);
    wr(1'b1, 0, 32'h0000_0009);
    probe(34'h100, 2'd1, 1'b1, 1'b1, "R7 machine store unlocked");
    probe(34'h9000, 2'd1, 1'b1, 1'b1, "R7 machine no match");
    wr(1'b1, 0, 32'h0000_0089);
    probe(34'h100, 2'd1, 1'b1, 1'b0, "R7 machine store locked read-only");
    probe(34'h100, 2'd0, 1'b1, 1'b1, "R7 machine load locked");
    probe(34'h9000, 2'd2, 1'b0, 1'b0, "R6 user fetch no match");
    wr(1'b0, 0, 32'h0000_5555);
    wr(1'b1, 0, 32'h0000_000F);
    rd(1'b0, 0, 32'h0000_1000, "R9 locked addr unchanged");
    rd(1'b1, 0, 32'h0000_0089, "R9 locked cfg unchanged");
  endtask

  task automatic t_mode2();
    do_reset();
    wr(1'b0, 0, 32'hFFFF_FFFF);
    wr(1'b1, 0, 32'h0000_0010);
    rd(1'b1, 0, 32'h0000_0010, "R1 cfg0 mode2 readback");
    probe(34'h200, 2'd1, 1'b0, 1'b1, "R6 mode 2 counts as off");
  endtask

  initial begin
    t_reset();
    t_napot();
    t_tor();
    t_machine();
    t_mode2();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule